// File: doc/BRIEF.md
# Operand Modifier Stage (Swizzle, Magnitude, Sign Flip)

This block sits between the register-file read and the arithmetic units of a vertex shader. It takes one four-component floating-point source operand and a small modifier field from the instruction. It rearranges the components in any pattern, including repeats, and can then strip the sign of every component, flip it, or do both. The modifiers act on the sign bit only, so NaN payloads and infinities keep all their other bits.

The fixed order is rearrange, then magnitude, then sign flip. With both modifiers set, every component therefore comes out as minus its magnitude. The modifier logic is a single layer of multiplexers and XOR gates feeding one optional output register. No pipeline stage is added beyond that register, which loads only while the pipeline enable is high.

Top module: `oswz_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_vec` becomes all zeros on that edge.
- R2: With `OUT_REG`=1, `res_vec` takes the modified operand on the rising edge where `en` is high, one cycle after the inputs are presented.
- R3: On a rising edge where `en` is low, `res_vec` keeps its previous value.
- R4: Output lane i (bits [32i+31:32i], lane 0 = x) takes source component `swz_sel[2i+1:2i]`, where 0=x, 1=y, 2=z and 3=w. Repeated selects are allowed.
- R5: The select value 8'hE4 (xyzw) with neither modifier set passes `src_vec` through bit for bit, NaN payloads included.
- R6: With `abs_en`=1 and `neg_en`=0, bit 31 of every lane is 0 and bits 30:0 equal the selected component.
- R7: With `neg_en`=1 and `abs_en`=0, bit 31 of every lane is the inverse of the selected component's sign bit, and bits 30:0 are unchanged.
- R8: With both modifiers set, bit 31 of every lane is 1 and bits 30:0 equal the selected component (minus magnitude).
- R9: Exponent and mantissa bits are never changed by any modifier, so infinities stay infinities and NaN payloads are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Pipeline enable; output register loads when high |
| src_vec | input | 128 | Source operand, lane 0 = x in the low bits |
| swz_sel | input | 8 | Four 2-bit component selects, lane 0 in bits 1:0 |
| abs_en | input | 1 | Clear the sign of every lane |
| neg_en | input | 1 | Flip the sign of every lane (applied after abs) |
| res_vec | output | 128 | Modified operand |

## Verification
A wrong lane select shows up as one output lane holding another lane's bit pattern. Distinct per-lane values make this visible on the very next enabled edge. A wrong modifier order or polarity appears only in bit 31 of a lane, so the stimulus mixes positive and negative inputs with all four modifier combinations. A modifier that reaches beyond the sign bit corrupts a NaN payload or turns an infinity into a NaN, and directed special values expose that in the same cycle. Hold behaviour is checked by changing the inputs while `en` is low and watching `res_vec` stay frozen.

// File: rtl/oswz_pkg.sv
package oswz_pkg;
  localparam int FP_W     = 32;
  localparam int NUM_COMP = 4;
  localparam int SEL_W    = $clog2(NUM_COMP);

  typedef enum logic [SEL_W-1:0] {
    COMP_X = 2'd0,
    COMP_Y = 2'd1,
    COMP_Z = 2'd2,
    COMP_W = 2'd3
  } comp_sel_e;

  typedef struct packed {
    logic abs_mag;
    logic flip_sgn;
  } sign_mod_t;
endpackage

// File: rtl/oswz_lane_mux.sv
module oswz_lane_mux #(
  parameter int W  = oswz_pkg::FP_W,
  parameter int NC = oswz_pkg::NUM_COMP,
  parameter int SW = oswz_pkg::SEL_W
) (
  input  logic [NC*W-1:0] src,
  input  logic [SW-1:0]   sel,
  output logic [W-1:0]    lane
);
  always_comb begin
    lane = '0;
    for (int c = 0; c < NC; c++) begin
      if (int'(sel) == c) lane = src[c*W +: W];
    end
  end
endmodule

// File: rtl/oswz_sign_mod.sv
module oswz_sign_mod #(
  parameter int W = oswz_pkg::FP_W
) (
  input  logic [W-1:0]         din,
  input  oswz_pkg::sign_mod_t  mode,
  output logic [W-1:0]         dout
);
  logic mag_sign;

  // magnitude first, then sign flip
  always_comb begin
    mag_sign = mode.abs_mag ? 1'b0 : din[W-1];
    dout     = {mag_sign ^ mode.flip_sgn, din[W-2:0]};
  end
endmodule

// File: rtl/oswz_out_stage.sv
module oswz_out_stage #(
  parameter int DW  = 128,
  parameter bit REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  generate
    if (REG) begin : g_reg
      logic [DW-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (en) q_r <= d;
      end
      assign q = q_r;
    end else begin : g_pass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/oswz_unit.sv
module oswz_unit #(
  parameter int W       = oswz_pkg::FP_W,
  parameter int NC      = oswz_pkg::NUM_COMP,
  parameter bit OUT_REG = 1'b1,
  localparam int SW     = oswz_pkg::SEL_W,
  localparam int VW     = NC * W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [VW-1:0]   src_vec,
  input  logic [NC*SW-1:0] swz_sel,
  input  logic            abs_en,
  input  logic            neg_en,
  output logic [VW-1:0]   res_vec
);
  oswz_pkg::sign_mod_t mode;
  logic [VW-1:0] swz_vec;
  logic [VW-1:0] mod_vec;

  assign mode.abs_mag  = abs_en;
  assign mode.flip_sgn = neg_en;

  generate
    for (genvar i = 0; i < NC; i++) begin : g_lane
      oswz_lane_mux #(.W(W), .NC(NC), .SW(SW)) u_mux (
        .src  (src_vec),
        .sel  (swz_sel[i*SW +: SW]),
        .lane (swz_vec[i*W +: W])
      );
      oswz_sign_mod #(.W(W)) u_sgn (
        .din  (swz_vec[i*W +: W]),
        .mode (mode),
        .dout (mod_vec[i*W +: W])
      );
    end
  endgenerate

  oswz_out_stage #(.DW(VW), .REG(OUT_REG)) u_out (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (mod_vec),
    .q   (res_vec)
  );
endmodule

// File: rtl/oswz_unit_chk.sv
module oswz_unit_chk #(
  parameter int W  = 32,
  parameter int NC = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [NC*W-1:0]   src_vec,
  input logic [NC*2-1:0]   swz_sel,
  input logic              abs_en,
  input logic              neg_en,
  input logic [NC*W-1:0]   res_vec
);
  logic [NC-1:0] sgn_bits;
  logic          seen_edge;

  always_comb
    for (int i = 0; i < NC; i++) sgn_bits[i] = res_vec[i*W + W-1];

  always_ff @(posedge clk) seen_edge <= 1'b1;

  generate
    if (OUT_REG) begin : g_chk
      // R1
      reset_clear_chk: assert property (@(posedge clk)
        rst |=> (res_vec == '0));
      // R3
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && !en && !$past(rst)) |=> $stable(res_vec));
      // R5
      identity_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !abs_en && !neg_en && swz_sel == 8'hE4) |=> (res_vec == $past(src_vec)));
      // R6
      abs_positive_chk: assert property (@(posedge clk) disable iff (rst)
        (en && abs_en && !neg_en) |=> (sgn_bits == '0));
      // R8
      neg_mag_chk: assert property (@(posedge clk) disable iff (rst)
        (en && abs_en && neg_en) |=> (sgn_bits == '1));
    end
  endgenerate
endmodule

bind oswz_unit oswz_unit_chk #(.W(W), .NC(NC), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .en(en), .src_vec(src_vec), .swz_sel(swz_sel),
  .abs_en(abs_en), .neg_en(neg_en), .res_vec(res_vec)
);

// File: tb/test_oswz_unit.sv
module test_oswz_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [NC*W-1:0] src_vec = '0;
  logic [7:0] swz_sel = 8'hE4;
  logic abs_en = 1'b0;
  logic neg_en = 1'b0;
  logic [NC*W-1:0] res_vec;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oswz_unit i_oswz_unit (
    .clk(clk), .rst(rst), .en(en), .src_vec(src_vec), .swz_sel(swz_sel),
    .abs_en(abs_en), .neg_en(neg_en), .res_vec(res_vec)
  );

  function automatic logic [NC*W-1:0] model(input logic [NC*W-1:0] s,
      input logic [7:0] sel, input logic a, input logic n);
    logic [NC*W-1:0] r;
    for (int i = 0; i < NC; i++) begin
      logic [W-1:0] c;
      c = s[sel[2*i +: 2]*W +: W];
      if (a) c[W-1] = 1'b0;
      if (n) c[W-1] = ~c[W-1];
      r[i*W +: W] = c;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [NC*W-1:0] exp_v);
    n_tests++;
    if (res_vec !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, res_vec, exp_v);
    end
  endtask

  // drive at falling edge, sample just after the next rising edge
  task automatic apply(input logic [NC*W-1:0] s, input logic [7:0] sel,
      input logic a, input logic n, input logic e);
    @(negedge clk);
    src_vec = s; swz_sel = sel; abs_en = a; neg_en = n; en = e;
    @(posedge clk); #1;
  endtask

  localparam logic [NC*W-1:0] V_MIX = {32'hC0800000, 32'h40400000, 32'hC0000000, 32'h3F800000};
  localparam logic [NC*W-1:0] V_SPC = {32'hFF800000, 32'h7F800000, 32'hFFC12345, 32'h7FA5A5A5};

  initial begin
    logic [NC*W-1:0] held;
    void'($urandom(32'h1234));
    repeat (2) @(posedge clk); #1;
    check("R1 reset", '0);
    @(negedge clk); rst = 1'b0;

    apply(V_MIX, 8'hE4, 0, 0, 1); check("R5 identity", V_MIX);
    apply(V_SPC, 8'hE4, 0, 0, 1); check("R5 identity NaN", V_SPC);
    apply(V_MIX, 8'h79, 0, 0, 1); check("R4 yzwy", model(V_MIX, 8'h79, 0, 0));
    apply(V_MIX, 8'hFF, 0, 0, 1);
    check("R4 wwww", {4{V_MIX[127:96]}});
    apply(V_MIX, 8'h1B, 0, 0, 1);
    check("R4 wzyx", {V_MIX[31:0], V_MIX[63:32], V_MIX[95:64], V_MIX[127:96]});
    apply(V_MIX, 8'hE4, 1, 0, 1);
    check("R6 abs", {32'h40800000, 32'h40400000, 32'h40000000, 32'h3F800000});
    apply(V_MIX, 8'hE4, 0, 1, 1);
    check("R7 neg", {32'h40800000, 32'hC0400000, 32'h40000000, 32'hBF800000});
    apply(V_MIX, 8'hE4, 1, 1, 1);
    check("R8 neg abs", {32'hC0800000, 32'hC0400000, 32'hC0000000, 32'hBF800000});
    apply(V_SPC, 8'hE4, 0, 1, 1);
    check("R9 neg specials", {32'h7F800000, 32'hFF800000, 32'h7FC12345, 32'hFFA5A5A5});
    apply(V_SPC, 8'hE4, 1, 0, 1);
    check("R9 abs specials", {32'h7F800000, 32'h7F800000, 32'h7FC12345, 32'h7FA5A5A5});

    held = res_vec;
    apply(V_MIX, 8'h00, 1, 1, 0); check("R3 hold", held);
    apply(V_SPC, 8'h55, 0, 1, 0); check("R3 hold again", held);
    apply(V_MIX, 8'h00, 0, 0, 1); check("R2 load after hold", {4{V_MIX[31:0]}});

    for (int k = 0; k < 300; k++) begin
      logic [NC*W-1:0] s;
      logic [7:0] sel;
      logic a, n, e;
      s = {$urandom, $urandom, $urandom, $urandom};
      sel = 8'($urandom);
      a = 1'($urandom); n = 1'($urandom); e = ($urandom % 4) != 0;
      held = res_vec;
      apply(s, sel, a, n, e);
      if (e) check("R2 R4 random", model(s, sel, a, n));
      else   check("R3 random hold", held);
    end

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; check("R1 reset mid-run", '0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule